// File: doc/BRIEF.md
# Dual Parallel Port with Direction Registers

This block is a memory-mapped peripheral with two 8-bit bidirectional ports, called A and B. Each bit of each port has a direction bit and an output-data bit. The processor reaches all four registers over an 8-bit data bus. Access uses a 2-bit register select, an active-high chip select, an active-low chip select and a write strobe. Toward the pads the block drives a separate value vector and output-enable vector per port. It also takes in a pin-level vector per port. Tri-state pad cells are outside the block.

The two ports read back differently. A read of port A always returns the pin levels after synchronization, including on bits that the block is driving. A read of port B returns the stored output value on output bits and the synchronized pin level on input bits. Software therefore gets back exactly what it wrote on port B's output bits, whatever the load on those pins does.

All incoming pin levels pass through a two-stage synchronizer before any read path sees them. Writes are registered. Read data is combinational from the selected register or the synchronized pins.

Top module: `dual_pport`

## Requirements
- R1: While `rst_n` is low, all four registers clear to 0 and both synchronizers clear to 0. All output enables and output values are therefore 0, and every line is an input.
- R2: A write stores `bus_wdata` into the selected register on the rising clock edge. A write happens when the chip is selected and `bus_we` is 1. A direction register reads back exactly the value last written to it.
- R3: Register select `bus_addr` decodes as follows: 0 selects port A data (output register on write, port read on read); 1 selects port A direction; 2 selects port B data; 3 selects port B direction.
- R4: The chip is selected only when `cs_hi` is 1 and `cs_lo_n` is 0. A write attempted with either select inactive changes no register.
- R5: Each bit of `pa_oe`/`pb_oe` equals the matching bit of that port's direction register, where 1 means output. Each bit of `pa_out`/`pb_out` equals the matching bit of that port's output register.
- R6: A read at address 0 returns the synchronized `pa_in` levels on every bit, whatever the direction and output register hold.
- R7: A read at address 2 returns, for each bit, the port B output register bit when the direction bit is 1, and the synchronized `pb_in` bit when it is 0.
- R8: A change on a pin input becomes visible in read data after exactly two rising clock edges.
- R9: `bus_rdata` is 0 unless the chip is selected and `bus_we` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_hi | input | 1 | Chip select, active high |
| cs_lo_n | input | 1 | Chip select, active low |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Register select |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (combinational) |
| pa_in | input | 8 | Port A pin levels |
| pa_out | output | 8 | Port A drive values |
| pa_oe | output | 8 | Port A output enables |
| pb_in | input | 8 | Port B pin levels |
| pb_out | output | 8 | Port B drive values |
| pb_oe | output | 8 | Port B output enables |

## Verification
The bench drives pin levels that disagree with the output registers on output bits. A design that treated port A like port B would return the written value instead of the pins. A design that read port B pins directly would return the pin level on output bits. Port B is also tested with mixed direction masks, which exposes a readback merge with the roles of the two sources swapped. The bench tries writes with each chip select inactive in turn, so a decoder that honours only one select is caught. It reads at the cycle boundary where a pin change should and should not yet be visible, which exposes a synchronizer that is one stage short or one stage long.

// File: rtl/pport_pkg.sv
package pport_pkg;

  typedef enum logic [1:0] {
    SEL_A_DATA = 2'd0,
    SEL_A_DIR  = 2'd1,
    SEL_B_DATA = 2'd2,
    SEL_B_DIR  = 2'd3
  } pport_sel_e;

  // Bitwise choice between stored output value and sampled pin level.
  function automatic logic [7:0] merge_rb(input logic [7:0] drive_v,
                                          input logic [7:0] dir_v,
                                          input logic [7:0] pin_v);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) begin
      r[i] = dir_v[i] ? drive_v[i] : pin_v[i];
    end
    return r;
  endfunction

endpackage

// File: rtl/pport_sync.sv
module pport_sync #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_in,
  output logic [W-1:0] d_out
);
  logic [W-1:0] stg1_q, stg2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg1_q <= '0;
      stg2_q <= '0;
    end else begin
      stg1_q <= d_in;
      stg2_q <= stg1_q;
    end
  end

  assign d_out = stg2_q;

  // Warm-up counter so the latency check only looks at cycles after reset.
  logic [1:0] warm_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) warm_q <= '0;
    else if (warm_q != 2'd3) warm_q <= warm_q + 2'd1;
  end

  // R8
  sync_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (warm_q == 2'd3) |-> (d_out == $past(d_in, 2)));
endmodule

// File: rtl/pport_side.sv
module pport_side
  import pport_pkg::*;
#(
  parameter int  W        = 8,
  parameter bit  PIN_ONLY = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_data,
  input  logic         wr_dir,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] pin_raw,
  output logic [W-1:0] drive,
  output logic [W-1:0] oe,
  output logic [W-1:0] dir_rb,
  output logic [W-1:0] data_rb,
  output logic [W-1:0] pin_sync
);
  logic [W-1:0] dir_q, out_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q <= '0;
      out_q <= '0;
    end else begin
      if (wr_dir)  dir_q <= wdata;
      if (wr_data) out_q <= wdata;
    end
  end

  pport_sync #(.W(W)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d_in (pin_raw),
    .d_out(pin_sync)
  );

  assign drive  = out_q;
  assign oe     = dir_q;
  assign dir_rb = dir_q;

  generate
    if (PIN_ONLY) begin : g_pin_rb
      assign data_rb = pin_sync;
    end else begin : g_mix_rb
      assign data_rb = merge_rb(out_q, dir_q, pin_sync);
    end
  endgenerate

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    !rst_n |-> (dir_q == '0 && out_q == '0));

  // R4
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_dir && !wr_data) |=> ($stable(dir_q) && $stable(out_q)));

  // R2
  dir_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_dir |=> (oe == $past(wdata)));

  // R2
  data_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_data |=> (drive == $past(wdata)));
endmodule

// File: rtl/dual_pport.sv
module dual_pport
  import pport_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cs_hi,
  input  logic         cs_lo_n,
  input  logic         bus_we,
  input  logic [1:0]   bus_addr,
  input  logic [W-1:0] bus_wdata,
  output logic [W-1:0] bus_rdata,
  input  logic [W-1:0] pa_in,
  output logic [W-1:0] pa_out,
  output logic [W-1:0] pa_oe,
  input  logic [W-1:0] pb_in,
  output logic [W-1:0] pb_out,
  output logic [W-1:0] pb_oe
);
  pport_sel_e sel;
  logic chip_sel, wr_hit, rd_hit;
  logic wr_a_data, wr_a_dir, wr_b_data, wr_b_dir;
  logic [W-1:0] a_dir_rb, a_data_rb, a_pin_s;
  logic [W-1:0] b_dir_rb, b_data_rb, b_pin_s;

  assign sel      = pport_sel_e'(bus_addr);
  assign chip_sel = cs_hi & ~cs_lo_n;
  assign wr_hit   = chip_sel & bus_we;
  assign rd_hit   = chip_sel & ~bus_we;

  assign wr_a_data = wr_hit && (sel == SEL_A_DATA);
  assign wr_a_dir  = wr_hit && (sel == SEL_A_DIR);
  assign wr_b_data = wr_hit && (sel == SEL_B_DATA);
  assign wr_b_dir  = wr_hit && (sel == SEL_B_DIR);

  pport_side #(.W(W), .PIN_ONLY(1'b1)) u_side_a (
    .clk(clk), .rst_n(rst_n),
    .wr_data(wr_a_data), .wr_dir(wr_a_dir), .wdata(bus_wdata),
    .pin_raw(pa_in), .drive(pa_out), .oe(pa_oe),
    .dir_rb(a_dir_rb), .data_rb(a_data_rb), .pin_sync(a_pin_s)
  );

  pport_side #(.W(W), .PIN_ONLY(1'b0)) u_side_b (
    .clk(clk), .rst_n(rst_n),
    .wr_data(wr_b_data), .wr_dir(wr_b_dir), .wdata(bus_wdata),
    .pin_raw(pb_in), .drive(pb_out), .oe(pb_oe),
    .dir_rb(b_dir_rb), .data_rb(b_data_rb), .pin_sync(b_pin_s)
  );

  always_comb begin
    bus_rdata = '0;
    if (rd_hit) begin
      case (sel)
        SEL_A_DATA: bus_rdata = a_data_rb;
        SEL_A_DIR:  bus_rdata = a_dir_rb;
        SEL_B_DATA: bus_rdata = b_data_rb;
        default:    bus_rdata = b_dir_rb;
      endcase
    end
  end

  // R9
  idle_rdata_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_hit |-> (bus_rdata == '0));

  // R6
  pa_pins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_hit && sel == SEL_A_DATA) |-> (bus_rdata == a_pin_s));

  // R7
  pb_outbits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_hit && sel == SEL_B_DATA) |-> (((bus_rdata ^ pb_out) & pb_oe) == '0));

  // R7
  pb_inbits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_hit && sel == SEL_B_DATA) |-> (((bus_rdata ^ b_pin_s) & ~pb_oe) == '0));

  // R4
  one_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({wr_a_data, wr_a_dir, wr_b_data, wr_b_dir}) <= 1);
endmodule

// File: tb/tb_dual_pport.sv
module tb_dual_pport;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_hi = 1'b0, cs_lo_n = 1'b1, bus_we = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic [7:0] pa_in = 8'h00, pb_in = 8'h00;
  logic [7:0] pa_out, pa_oe, pb_out, pb_oe;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  dual_pport dut (
    .clk(clk), .rst_n(rst_n), .cs_hi(cs_hi), .cs_lo_n(cs_lo_n),
    .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .pa_in(pa_in), .pa_out(pa_out), .pa_oe(pa_oe),
    .pb_in(pb_in), .pb_out(pb_out), .pb_oe(pb_oe)
  );

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%02h exp=%02h", req, got, exp);
    end
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [7:0] d,
                           input logic h, input logic ln);
    @(negedge clk);
    cs_hi = h; cs_lo_n = ln; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    cs_hi = 1'b0; cs_lo_n = 1'b1; bus_we = 1'b0;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    cs_hi = 1'b1; cs_lo_n = 1'b0; bus_we = 1'b0; bus_addr = a;
    #2;
    d = bus_rdata;
    cs_hi = 1'b0; cs_lo_n = 1'b1;
  endtask

  function automatic logic [7:0] exp_b(input logic [7:0] o, input logic [7:0] dr,
                                       input logic [7:0] p);
    return (o & dr) | (p & ~dr);
  endfunction

  task automatic t_reset;
    logic [7:0] v;
    check("R1 pa_oe", pa_oe, 8'h00);
    check("R1 pb_oe", pb_oe, 8'h00);
    check("R1 pa_out", pa_out, 8'h00);
    check("R1 pb_out", pb_out, 8'h00);
    bus_read(2'd1, v); check("R1 dir A", v, 8'h00);
    bus_read(2'd3, v); check("R1 dir B", v, 8'h00);
    bus_read(2'd2, v); check("R1 port B", v, 8'h00);
  endtask

  task automatic t_decode;
    logic [7:0] v;
    bus_write(2'd0, 8'h5A, 1'b1, 1'b0);
    bus_write(2'd1, 8'hC3, 1'b1, 1'b0);
    bus_write(2'd2, 8'h96, 1'b1, 1'b0);
    bus_write(2'd3, 8'h3C, 1'b1, 1'b0);
    bus_read(2'd1, v); check("R2 R3 dir A", v, 8'hC3);
    bus_read(2'd3, v); check("R2 R3 dir B", v, 8'h3C);
    check("R5 pa_out", pa_out, 8'h5A);
    check("R5 pa_oe", pa_oe, 8'hC3);
    check("R5 pb_out", pb_out, 8'h96);
    check("R5 pb_oe", pb_oe, 8'h3C);
  endtask

  task automatic t_chipsel;
    logic [7:0] v;
    bus_write(2'd1, 8'hFF, 1'b0, 1'b0);
    bus_read(2'd1, v); check("R4 cs_hi low", v, 8'hC3);
    bus_write(2'd3, 8'hFF, 1'b1, 1'b1);
    bus_read(2'd3, v); check("R4 cs_lo_n high", v, 8'h3C);
    bus_write(2'd0, 8'h00, 1'b0, 1'b1);
    check("R4 pa_out held", pa_out, 8'h5A);
    @(negedge clk);
    cs_hi = 1'b0; cs_lo_n = 1'b0; bus_we = 1'b0; bus_addr = 2'd1;
    #2 check("R9 idle rdata", bus_rdata, 8'h00);
    cs_hi = 1'b1; bus_we = 1'b1;
    #2 check("R9 rdata during write", bus_rdata, 8'h00);
    @(negedge clk);
    cs_hi = 1'b0; cs_lo_n = 1'b1; bus_we = 1'b0;
    bus_write(2'd1, 8'hC3, 1'b1, 1'b0);
  endtask

  task automatic t_port_a;
    logic [7:0] v;
    pa_in = 8'h0F;
    repeat (3) @(negedge clk);
    bus_read(2'd0, v); check("R6 pins on mixed dir", v, 8'h0F);
    bus_write(2'd1, 8'hFF, 1'b1, 1'b0);
    bus_read(2'd0, v); check("R6 pins on all-out", v, 8'h0F);
  endtask

  task automatic t_port_b;
    logic [7:0] v;
    pb_in = 8'h69;
    repeat (3) @(negedge clk);
    bus_read(2'd2, v); check("R7 mixed", v, exp_b(8'h96, 8'h3C, 8'h69));
    bus_write(2'd3, 8'hF0, 1'b1, 1'b0);
    bus_write(2'd2, 8'h00, 1'b1, 1'b0);
    pb_in = 8'hFF;
    repeat (3) @(negedge clk);
    bus_read(2'd2, v); check("R7 upper out", v, exp_b(8'h00, 8'hF0, 8'hFF));
    bus_write(2'd3, 8'hFF, 1'b1, 1'b0);
    bus_write(2'd2, 8'hA5, 1'b1, 1'b0);
    bus_read(2'd2, v); check("R7 all out", v, 8'hA5);
  endtask

  task automatic t_sync;
    pa_in = 8'h00;
    repeat (3) @(negedge clk);
    cs_hi = 1'b1; cs_lo_n = 1'b0; bus_we = 1'b0; bus_addr = 2'd0;
    pa_in = 8'hA5;
    @(negedge clk);
    check("R8 after one edge", bus_rdata, 8'h00);
    @(negedge clk);
    check("R8 after two edges", bus_rdata, 8'hA5);
    cs_hi = 1'b0; cs_lo_n = 1'b1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_decode();
    t_chipsel();
    t_port_a();
    t_port_b();
    t_sync();
    done = 1'b1;
  end

  initial begin
    fork
      begin wait (done); end
      begin
        repeat (5000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog got=hang exp=finish");
      end
    join_any
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule